// File: doc/BRIEF.md
# Rotating Tiled-View Address Generator

This block converts a pixel coordinate into an address within a tiled address space. Each request names a pixel format, a three-bit view orientation and an X/Y coordinate pair. The block checks the coordinate against the limits that apply to that format. It then mirrors either axis as the orientation asks and can swap the two axes to produce rotated views. Finally it packs the resulting offset under a header that carries the view code and the format code. The line stride for the chosen orientation is reported alongside the address.

The block has one register stage. A request presented with `in_valid` high appears on the outputs one clock later, together with `o_strobe`. If the coordinate is legal, `o_ok` is high. If it is not, `o_ok` is low and the address reads as zero. Mapping the tiled address to physical memory is left to downstream logic.

The coordinate space is 8192 x 4096 bytes, so there are 13 width bits and 12 height bits. Formats with wider pixels give up low coordinate bits. They recover them as a left shift of the offset.

Top module: `tile_addr_gen`

## Requirements
- R1: Timing. A request accepted with `in_valid` high on a clock edge produces `o_strobe` high after that edge, with results for that request. When `in_valid` is low, `o_strobe` is low after the edge. `o_ok` is never high while `o_strobe` is low.
- R2: Format code. Address bits [28:27] carry the format code. The codes are: 0 for 8-bit pixels, 1 for 16-bit, 2 for 32-bit, 3 for linear (page) mode.
- R3: View code. Address bits [31:29] carry the orientation code unchanged. Orientation bit 0 mirrors X, bit 1 mirrors Y and bit 2 swaps the axes.
- R4: Axis widths. X spans 13 − sx bits and Y spans 12 − sy bits. The shift pairs (sx, sy) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (0,0) for linear mode.
- R5: Out of range. If x exceeds the X mask or y exceeds the Y mask, `o_ok` is low and the whole address is 0.
- R6: Mirroring. A mirror bit replaces that coordinate with its bitwise XOR against the axis mask. This is applied before the axes are swapped.
- R7: Unswapped offset. Without the swap bit, the offset is (y << xbits) + x, shifted left by sx + sy. It sits in address bits [24:0], and bits [26:25] are zero.
- R8: Swapped offset. With the swap bit set, the offset is (x << ybits) + y, shifted left by sx + sy.
- R9: Stride. `o_stride` is 1 << (12 + sx) when the axes are swapped and 1 << (13 + sy) when they are not. It is computed for every request, in range or not.
- R10: Linear mode. Format 3 treats the coordinate as a plain linear offset y·8192 + x (unswapped) with no alignment shift.
- R11: Reset. After a synchronous reset, `o_strobe`, `o_ok`, `o_addr` and `o_stride` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_fmt | input | 2 | Pixel format code |
| in_view | input | 3 | Orientation: bit0 X mirror, bit1 Y mirror, bit2 axis swap |
| in_x | input | 16 | X coordinate |
| in_y | input | 16 | Y coordinate |
| o_strobe | output | 1 | Result present (one cycle after request) |
| o_ok | output | 1 | Coordinate was within range |
| o_addr | output | 32 | Tiled-space address with view and format header |
| o_stride | output | 32 | Line stride for the requested orientation |

## Verification
The boundary cases are the hardest to reach from the ports. One is a coordinate exactly at the mask of a shortened axis, where 4095 is legal for X in 32-bit mode and 4096 is not. The other is the same corner under a mirror, where it must fold to offset zero. Directed vectors place coordinates one below, at, and one above each format's limits under every orientation. A long run of requests with coordinates drawn slightly past the full container then covers the mixed in-range and out-of-range traffic, sent back to back and with idle gaps.

// File: rtl/tile_pkg.sv
package tile_pkg;

    // Container geometry in bytes: 2^13 wide, 2^12 high
    localparam int TP_WBITS = 13;
    localparam int TP_HBITS = 12;
    localparam int TP_CW    = 16;
    localparam int TP_AW    = 32;
    localparam int TP_SW    = 32;

    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_B16 = 2'd1,
        FMT_B32 = 2'd2,
        FMT_LIN = 2'd3
    } fmt_e;

    // Bits that a wider pixel drops from each axis
    typedef struct packed {
        logic xs;
        logic ys;
    } geom_t;

    // Orientation code, bit0 = mirror X, bit1 = mirror Y, bit2 = swap
    typedef struct packed {
        logic swap;
        logic mir_y;
        logic mir_x;
    } view_t;

    function automatic geom_t geom_of(input fmt_e f);
        geom_t g;
        case (f)
            FMT_B16: g = '{xs: 1'b0, ys: 1'b1};
            FMT_B32: g = '{xs: 1'b1, ys: 1'b1};
            default: g = '{xs: 1'b0, ys: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tile_range_chk.sv
module tile_range_chk
    import tile_pkg::*;
#(
    parameter int WBITS = TP_WBITS,
    parameter int HBITS = TP_HBITS,
    parameter int CW    = TP_CW
) (
    input  geom_t            g,
    input  logic [CW-1:0]    x,
    input  logic [CW-1:0]    y,
    output logic [WBITS-1:0] xmask,
    output logic [HBITS-1:0] ymask,
    output logic             in_range
);
    localparam logic [WBITS-1:0] XFULL = '1;
    localparam logic [HBITS-1:0] YFULL = '1;

    always_comb begin
        xmask    = XFULL >> g.xs;
        ymask    = YFULL >> g.ys;
        in_range = (x <= CW'(xmask)) && (y <= CW'(ymask));
    end
endmodule

// File: rtl/tile_xform.sv
module tile_xform
    import tile_pkg::*;
#(
    parameter int WBITS = TP_WBITS,
    parameter int HBITS = TP_HBITS,
    localparam int OFFW = WBITS + HBITS
) (
    input  geom_t            g,
    input  view_t            v,
    input  logic [WBITS-1:0] x,
    input  logic [HBITS-1:0] y,
    input  logic [WBITS-1:0] xmask,
    input  logic [HBITS-1:0] ymask,
    output logic [OFFW-1:0]  off
);
    logic [WBITS-1:0] xm;
    logic [HBITS-1:0] ym;
    logic [OFFW-1:0]  raw;
    int unsigned      xbits;
    int unsigned      ybits;
    int unsigned      align;

    always_comb begin
        xm    = x ^ (v.mir_x ? xmask : '0);
        ym    = y ^ (v.mir_y ? ymask : '0);
        xbits = WBITS - int'(g.xs);
        ybits = HBITS - int'(g.ys);
        align = int'(g.xs) + int'(g.ys);
        if (v.swap)
            raw = (OFFW'(xm) << ybits) + OFFW'(ym);
        else
            raw = (OFFW'(ym) << xbits) + OFFW'(xm);
        off = raw << align;
    end
endmodule

// File: rtl/tile_stride.sv
module tile_stride
    import tile_pkg::*;
#(
    parameter int WBITS = TP_WBITS,
    parameter int HBITS = TP_HBITS,
    parameter int SW    = TP_SW
) (
    input  geom_t         g,
    input  logic          swap,
    output logic [SW-1:0] stride
);
    localparam logic [SW-1:0] ONE = SW'(1);

    always_comb begin
        if (swap)
            stride = ONE << (HBITS + int'(g.xs));
        else
            stride = ONE << (WBITS + int'(g.ys));
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_pkg::*;
#(
    parameter int WBITS = TP_WBITS,
    parameter int HBITS = TP_HBITS,
    parameter int CW    = TP_CW,
    parameter int AW    = TP_AW,
    parameter int SW    = TP_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_fmt,
    input  logic [2:0]    in_view,
    input  logic [CW-1:0] in_x,
    input  logic [CW-1:0] in_y,
    output logic          o_strobe,
    output logic          o_ok,
    output logic [AW-1:0] o_addr,
    output logic [SW-1:0] o_stride
);
    localparam int OFFW = WBITS + HBITS;
    localparam int HDRW = 5;

    geom_t            geo;
    view_t            vw;
    logic [WBITS-1:0] xmask;
    logic [HBITS-1:0] ymask;
    logic             in_range;
    logic [OFFW-1:0]  off;
    logic [SW-1:0]    stride_c;
    logic [AW-1:0]    addr_c;

    always_comb begin
        geo = geom_of(fmt_e'(in_fmt));
        vw  = view_t'(in_view);
    end

    tile_range_chk #(.WBITS(WBITS), .HBITS(HBITS), .CW(CW)) u_rng (
        .g(geo), .x(in_x), .y(in_y),
        .xmask(xmask), .ymask(ymask), .in_range(in_range)
    );

    tile_xform #(.WBITS(WBITS), .HBITS(HBITS)) u_xf (
        .g(geo), .v(vw),
        .x(in_x[WBITS-1:0]), .y(in_y[HBITS-1:0]),
        .xmask(xmask), .ymask(ymask), .off(off)
    );

    tile_stride #(.WBITS(WBITS), .HBITS(HBITS), .SW(SW)) u_st (
        .g(geo), .swap(vw.swap), .stride(stride_c)
    );

    always_comb begin
        if (in_range)
            addr_c = AW'(off) | (AW'({in_view, in_fmt}) << (AW - HDRW));
        else
            addr_c = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_strobe <= 1'b0;
            o_ok     <= 1'b0;
            o_addr   <= '0;
            o_stride <= '0;
        end else begin
            o_strobe <= in_valid;
            o_ok     <= in_valid && in_range;
            if (in_valid) begin
                o_addr   <= addr_c;
                o_stride <= stride_c;
            end
        end
    end
endmodule

// File: rtl/tile_addr_chk.sv
module tile_addr_chk #(
    parameter int WBITS = 13,
    parameter int HBITS = 12,
    parameter int CW    = 16,
    parameter int AW    = 32,
    parameter int SW    = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    in_fmt,
    input logic [2:0]    in_view,
    input logic [CW-1:0] in_x,
    input logic [CW-1:0] in_y,
    input logic          o_strobe,
    input logic          o_ok,
    input logic [AW-1:0] o_addr,
    input logic [SW-1:0] o_stride
);
    logic [CW-1:0] xlim;
    logic [CW-1:0] ylim;

    always_comb begin
        xlim = CW'((1 << WBITS) - 1) >> (in_fmt == 2'd2);
        ylim = CW'((1 << HBITS) - 1) >> ((in_fmt == 2'd1) || (in_fmt == 2'd2));
    end

    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> o_strobe);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !o_strobe);
    assert_ok_needs_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        o_ok |-> o_strobe);
    assert_fmt_field_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!o_ok || o_addr[AW-4:AW-5] == $past(in_fmt)));
    assert_view_field_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!o_ok || o_addr[AW-1:AW-3] == $past(in_view)));
    assert_oob_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_x > xlim || in_y > ylim)) |=> (!o_ok && o_addr == '0));
    assert_align_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == 2'd2) |=> (o_addr[1:0] == 2'b00));
    assert_stride_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        o_strobe |-> ($countones(o_stride) == 1));
endmodule

bind tile_addr_gen tile_addr_chk #(
    .WBITS(WBITS), .HBITS(HBITS), .CW(CW), .AW(AW), .SW(SW)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_view(in_view), .in_x(in_x), .in_y(in_y), .o_strobe(o_strobe),
    .o_ok(o_ok), .o_addr(o_addr), .o_stride(o_stride)
);

// File: tb/sim_tile_addr_gen.sv
module sim_tile_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_view = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        o_strobe;
    logic        o_ok;
    logic [31:0] o_addr;
    logic [31:0] o_stride;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [64:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    tile_addr_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_view(in_view), .in_x(in_x), .in_y(in_y), .o_strobe(o_strobe),
        .o_ok(o_ok), .o_addr(o_addr), .o_stride(o_stride)
    );

    // Reference built from the stated rules
    function automatic logic [64:0] model(input logic [1:0] f, input logic [2:0] o,
                                          input int x, input int y);
        int sx = (f == 2) ? 1 : 0;
        int sy = (f == 1 || f == 2) ? 1 : 0;
        int xb = 13 - sx;
        int yb = 12 - sy;
        int xm = (1 << xb) - 1;
        int ym = (1 << yb) - 1;
        int xx = x;
        int yy = y;
        longint off;
        logic [31:0] a;
        logic [31:0] s;
        logic ok;
        s  = o[2] ? (32'd1 << (12 + sx)) : (32'd1 << (13 + sy));
        ok = (x <= xm) && (y <= ym);
        if (o[0]) xx = xx ^ xm;
        if (o[1]) yy = yy ^ ym;
        if (o[2]) off = (longint'(xx) << yb) + yy;
        else      off = (longint'(yy) << xb) + xx;
        off = off << (sx + sy);
        a = ok ? ({o, f, 27'd0} | 32'(off)) : 32'd0;
        return {ok, a, s};
    endfunction

    task automatic send(input logic [1:0] f, input logic [2:0] o,
                        input int x, input int y, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = f;
        in_view  = o;
        in_x     = 16'(x);
        in_y     = 16'(y);
        exp_q.push_back(model(f, o, x, y));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (!rst && o_strobe) begin
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected strobe: got 1 expected 0");
            end else begin
                logic [64:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({o_ok, o_addr, o_stride} !== e) begin
                    errors++;
                    $display("FAIL %s: got ok=%0b addr=%h stride=%h expected ok=%0b addr=%h stride=%h",
                             t, o_ok, o_addr, o_stride, e[64], e[63:32], e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        vectors++;
        if ({o_strobe, o_ok, o_addr, o_stride} !== 66'd0) begin
            errors++;
            $display("FAIL R11 reset state: got %h expected 0",
                     {o_strobe, o_ok, o_addr, o_stride});
        end
        @(negedge clk);
        rst = 1'b0;

        // Plain views in each format
        send(2'd0, 3'd0, 5, 3, "R7 8-bit unswapped");
        send(2'd1, 3'd0, 100, 2000, "R4 16-bit geometry");
        send(2'd2, 3'd0, 4095, 2047, "R4 32-bit max corner");
        send(2'd3, 3'd0, 1234, 777, "R10 linear mode");
        send(2'd2, 3'd0, 7, 9, "R2 format code 32-bit");
        idle(2);
        // Mirroring and swap
        send(2'd0, 3'd1, 0, 0, "R6 mirror X origin");
        send(2'd0, 3'd2, 10, 0, "R6 mirror Y");
        send(2'd2, 3'd3, 4095, 2047, "R6 mirror both folds to zero");
        send(2'd0, 3'd4, 5, 3, "R8 swap 8-bit");
        send(2'd2, 3'd5, 12, 34, "R8 swap 32-bit mirror");
        send(2'd1, 3'd6, 333, 1, "R9 swap stride 16-bit");
        send(2'd1, 3'd7, 8191, 2047, "R3 view 7 code");
        idle(1);
        // Range limits
        send(2'd2, 3'd0, 4096, 0, "R5 32-bit X one past");
        send(2'd1, 3'd0, 8191, 2048, "R5 16-bit Y one past");
        send(2'd0, 3'd0, 8191, 4095, "R5 8-bit at limit");
        send(2'd0, 3'd4, 8192, 0, "R5 8-bit X one past swapped");
        send(2'd3, 3'd1, 0, 4096, "R5 linear Y one past");
        idle(3);
        // Every format and view at the limits of its axes
        for (int f = 0; f < 4; f++)
            for (int o = 0; o < 8; o++) begin
                int xl = (f == 2) ? 4095 : 8191;
                int yl = (f == 1 || f == 2) ? 2047 : 4095;
                send(2'(f), 3'(o), xl, yl, "R3 all views limit");
                send(2'(f), 3'(o), xl + 1, 1, "R5 all views X past");
                send(2'(f), 3'(o), 1, yl + 1, "R5 all views Y past");
            end
        // Mixed random traffic with occasional idle gaps
        for (int i = 0; i < 400; i++) begin
            send(2'($urandom_range(3)), 3'($urandom_range(7)),
                 int'($urandom_range(8400)), int'($urandom_range(4300)), "R7 random stream");
            if ($urandom_range(4) == 0) idle(1);
        end
        idle(4);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 results missing: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule